// File: doc/BRIEF.md
# PCI-to-PCI Bridge Type-1 Configuration Registers

This block holds the bridge-specific registers of a type-1 configuration header: bus numbers, secondary latency timer, the I/O, memory and prefetchable address windows with their upper extensions, the expansion ROM address, the interrupt line and pin, and bridge control. Configuration software reaches it through a dword-wide port. The port carries a dword index, write data, byte enables and a write strobe. Reads are combinational on the dword index.

Dword indices below 6 (byte offsets below 0x18) belong to the common header. For those the block raises a forward flag, returns zero and changes no state. The stored window registers are expanded into full byte-address base and inclusive limit values, which a separate window decoder consumes. The memory windows have 1 MiB granularity and the I/O window has 4 KiB granularity.

Each base or limit register passes its write through a writable mask. Its low nibble holds the addressing type and is fixed to the low nibble of that mask. An upper-address register accepts writes only when its type nibble advertises wide addressing.

Top module: `p2p_bridge_cfg`

## Requirements
- R1: For a dword index below 6, `cfg_fwd_o` is 1 and `cfg_rdata_o` is 0, and a write changes no register. For every other index, `cfg_fwd_o` is 0.
- R2: Index 6 reads {latency timer, subordinate bus, secondary bus, primary bus}, from byte 3 down to byte 0. The three bus bytes are fully writable.
- R3: A write to the latency timer changes only the bits set in `LAT_MASK`. All other bits keep their value.
- R4: Index 7 holds I/O base in [7:0] and I/O limit in [15:8]. Index 8 holds memory base in [15:0] and memory limit in [31:16]. Index 9 holds the prefetchable base and limit in the same layout. The stored value is the written value ANDed with its mask (`IO_MASK`, `MEM_MASK`, `PREF_MASK`). Bits [3:0] always equal the mask's bits [3:0].
- R5: Bits [31:16] of index 7 (secondary status) read 0, and writes to them are dropped.
- R6: Index 12 holds the I/O base upper 16 bits in [15:0] and the I/O limit upper 16 bits in [31:16]. It is written only when the I/O type nibble equals 1. Otherwise it is unchanged.
- R7: Index 10 holds the prefetchable base upper 32 bits and index 11 the prefetchable limit upper 32 bits. Both are written only when the prefetchable type nibble equals 1. Otherwise they are unchanged.
- R8: Index 15 reads {bridge control[31:16], interrupt pin[15:8], interrupt line[7:0]}. The interrupt pin is the constant `IRQ_PIN` and is read-only.
- R9: Index 13 and indices 16 to 63 read 0, and writes to them change nothing.
- R10: After reset, all registers read 0, except that each base/limit field keeps its mask's type nibble and the interrupt pin reads `IRQ_PIN`.
- R11: The window outputs are formed as follows:
  - I/O base = {io upper base, io_base[7:4], 12'h000}.
  - I/O limit = {io upper limit, io_limit[7:4], 12'hFFF}.
  - Memory base = {mem_base[15:4], 20'h0}.
  - Memory limit = {mem_limit[15:4], 20'hFFFFF}.
  - Prefetchable base = {upper base, pref_base[15:4], 20'h0}.
  - Prefetchable limit = {upper limit, pref_limit[15:4], 20'hFFFFF}.
- R12: A write updates only the byte lanes whose `cfg_be_i` bit is 1 (bit n covers data bits [8n+7:8n]). With no write strobe, no register changes.
- R13: Index 14 is the expansion ROM address. It stores the written value ANDed with `ROM_MASK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe, sampled on the rising edge |
| cfg_dw_i | input | 6 | Dword index (byte offset / 4) |
| cfg_be_i | input | 4 | Byte-lane enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_dw_i` |
| cfg_fwd_o | output | 1 | Index belongs to the common header |
| pri_bus_o | output | 8 | Primary bus number |
| sec_bus_o | output | 8 | Secondary bus number |
| sub_bus_o | output | 8 | Subordinate bus number |
| sec_lat_o | output | 8 | Secondary latency timer |
| io_win_base_o | output | 32 | I/O window base address |
| io_win_limit_o | output | 32 | I/O window inclusive limit |
| mem_win_base_o | output | 32 | Memory window base address |
| mem_win_limit_o | output | 32 | Memory window inclusive limit |
| pf_win_base_o | output | 64 | Prefetchable window base address |
| pf_win_limit_o | output | 64 | Prefetchable window inclusive limit |
| rom_addr_o | output | 32 | Expansion ROM address register |
| bridge_ctl_o | output | 16 | Bridge control |
| irq_line_o | output | 8 | Interrupt line |

## Verification
The assertions take for granted two things about the inputs. First, the write strobe, dword index and byte enables are known values on every clock edge after reset. Second, a type nibble never changes after reset, because it comes from a mask parameter. The bench drives all inputs on the falling edge with defined values only. It sweeps every dword index against all sixteen byte-enable patterns and several data patterns, so no strobe is ever left unknown. A second instance with narrow type nibbles exercises the case where writes to the upper-address registers are ignored.

// File: rtl/p2p_cfg_pkg.sv
package p2p_cfg_pkg;
  localparam int DW_W      = 6;
  localparam int HDR_LAST  = 5;
  localparam logic [DW_W-1:0] DW_BUS    = 6'd6;
  localparam logic [DW_W-1:0] DW_IO     = 6'd7;
  localparam logic [DW_W-1:0] DW_MEM    = 6'd8;
  localparam logic [DW_W-1:0] DW_PF     = 6'd9;
  localparam logic [DW_W-1:0] DW_PF_UPB = 6'd10;
  localparam logic [DW_W-1:0] DW_PF_UPL = 6'd11;
  localparam logic [DW_W-1:0] DW_IO_UP  = 6'd12;
  localparam logic [DW_W-1:0] DW_ROM    = 6'd14;
  localparam logic [DW_W-1:0] DW_IRQ    = 6'd15;
  localparam logic [3:0] TYPE_WIDE = 4'h1;

  function automatic logic [31:0] lane_merge(logic [31:0] old_v, logic [31:0] new_v,
                                             logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/p2p_masked_reg.sv
module p2p_masked_reg #(
  parameter int          W       = 16,
  parameter logic [W-1:0] MASK   = '1,
  parameter bit          KEEP_RO = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   q_o
);
  localparam int NB = W / 8;
  localparam logic [W-1:0] TYPE_BITS = KEEP_RO ? '0 : {{(W-4){1'b0}}, MASK[3:0]};

  logic [W-1:0] merged, nxt;

  always_comb begin
    for (int b = 0; b < NB; b++) merged[b*8 +: 8] = be_i[b] ? wdata_i[b*8 +: 8] : q_o[b*8 +: 8];
  end

  generate
    if (KEEP_RO) begin : g_keep
      assign nxt = (q_o & ~MASK) | (merged & MASK);
    end else begin : g_force
      assign nxt = (merged & MASK) | TYPE_BITS;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= TYPE_BITS;
    else if (we_i) q_o <= nxt;
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));

  generate
    if (KEEP_RO) begin : g_ro_chk
      p_ro_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> ((q_o & ~MASK) == ($past(q_o) & ~MASK)));
    end else begin : g_type_chk
      p_type_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (q_o[3:0] == $past(q_o[3:0])));
    end
  endgenerate
endmodule

// File: rtl/p2p_window_dec.sv
module p2p_window_dec (
  input  logic [7:0]  io_base_i,
  input  logic [7:0]  io_lim_i,
  input  logic [31:0] io_up_i,
  input  logic [15:0] mem_base_i,
  input  logic [15:0] mem_lim_i,
  input  logic [15:0] pf_base_i,
  input  logic [15:0] pf_lim_i,
  input  logic [31:0] pf_up_base_i,
  input  logic [31:0] pf_up_lim_i,
  output logic [31:0] io_base_o,
  output logic [31:0] io_lim_o,
  output logic [31:0] mem_base_o,
  output logic [31:0] mem_lim_o,
  output logic [63:0] pf_base_o,
  output logic [63:0] pf_lim_o
);
  localparam int IO_GRAN  = 12;
  localparam int MEM_GRAN = 20;

  assign io_base_o  = {io_up_i[15:0],  io_base_i[7:4], {IO_GRAN{1'b0}}};
  assign io_lim_o   = {io_up_i[31:16], io_lim_i[7:4],  {IO_GRAN{1'b1}}};
  assign mem_base_o = {mem_base_i[15:4], {MEM_GRAN{1'b0}}};
  assign mem_lim_o  = {mem_lim_i[15:4],  {MEM_GRAN{1'b1}}};
  assign pf_base_o  = {pf_up_base_i, pf_base_i[15:4], {MEM_GRAN{1'b0}}};
  assign pf_lim_o   = {pf_up_lim_i,  pf_lim_i[15:4],  {MEM_GRAN{1'b1}}};
endmodule

// File: rtl/p2p_bridge_cfg.sv
module p2p_bridge_cfg
  import p2p_cfg_pkg::*;
#(
  parameter logic [7:0]  LAT_MASK  = 8'hF8,
  parameter logic [7:0]  IO_MASK   = 8'hF1,
  parameter logic [15:0] MEM_MASK  = 16'hFFF0,
  parameter logic [15:0] PREF_MASK = 16'hFFF1,
  parameter logic [31:0] ROM_MASK  = 32'hFFFF_F801,
  parameter logic [7:0]  IRQ_PIN   = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_dw_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic        cfg_fwd_o,
  output logic [7:0]  pri_bus_o,
  output logic [7:0]  sec_bus_o,
  output logic [7:0]  sub_bus_o,
  output logic [7:0]  sec_lat_o,
  output logic [31:0] io_win_base_o,
  output logic [31:0] io_win_limit_o,
  output logic [31:0] mem_win_base_o,
  output logic [31:0] mem_win_limit_o,
  output logic [63:0] pf_win_base_o,
  output logic [63:0] pf_win_limit_o,
  output logic [31:0] rom_addr_o,
  output logic [15:0] bridge_ctl_o,
  output logic [7:0]  irq_line_o
);
  logic        wr_bus, wr_io, wr_mem, wr_pf, wr_pfub, wr_pful, wr_ioup, wr_rom, wr_irq;
  logic [23:0] bus_q;
  logic [7:0]  io_base_q, io_lim_q;
  logic [15:0] mem_base_q, mem_lim_q, pf_base_q, pf_lim_q;
  logic [31:0] pf_up_base_q, pf_up_lim_q, io_up_q, rom_q;
  logic [15:0] brctl_q;
  logic [7:0]  irq_line_q;
  logic        io_wide, pf_wide;

  assign cfg_fwd_o = (cfg_dw_i <= 6'(HDR_LAST));
  assign wr_bus  = cfg_we_i && cfg_dw_i == DW_BUS;
  assign wr_io   = cfg_we_i && cfg_dw_i == DW_IO;
  assign wr_mem  = cfg_we_i && cfg_dw_i == DW_MEM;
  assign wr_pf   = cfg_we_i && cfg_dw_i == DW_PF;
  assign wr_pfub = cfg_we_i && cfg_dw_i == DW_PF_UPB;
  assign wr_pful = cfg_we_i && cfg_dw_i == DW_PF_UPL;
  assign wr_ioup = cfg_we_i && cfg_dw_i == DW_IO_UP;
  assign wr_rom  = cfg_we_i && cfg_dw_i == DW_ROM;
  assign wr_irq  = cfg_we_i && cfg_dw_i == DW_IRQ;

  assign io_wide = (io_base_q[3:0] == TYPE_WIDE);
  assign pf_wide = (pf_base_q[3:0] == TYPE_WIDE);

  p2p_masked_reg #(.W(8), .MASK(LAT_MASK), .KEEP_RO(1'b1)) u_lat (
    .clk_i, .rst_ni, .we_i(wr_bus), .be_i(cfg_be_i[3]),
    .wdata_i(cfg_wdata_i[31:24]), .q_o(sec_lat_o));

  p2p_masked_reg #(.W(8), .MASK(IO_MASK)) u_io_base (
    .clk_i, .rst_ni, .we_i(wr_io), .be_i(cfg_be_i[0]),
    .wdata_i(cfg_wdata_i[7:0]), .q_o(io_base_q));
  p2p_masked_reg #(.W(8), .MASK(IO_MASK)) u_io_lim (
    .clk_i, .rst_ni, .we_i(wr_io), .be_i(cfg_be_i[1]),
    .wdata_i(cfg_wdata_i[15:8]), .q_o(io_lim_q));
  p2p_masked_reg #(.W(16), .MASK(MEM_MASK)) u_mem_base (
    .clk_i, .rst_ni, .we_i(wr_mem), .be_i(cfg_be_i[1:0]),
    .wdata_i(cfg_wdata_i[15:0]), .q_o(mem_base_q));
  p2p_masked_reg #(.W(16), .MASK(MEM_MASK)) u_mem_lim (
    .clk_i, .rst_ni, .we_i(wr_mem), .be_i(cfg_be_i[3:2]),
    .wdata_i(cfg_wdata_i[31:16]), .q_o(mem_lim_q));
  p2p_masked_reg #(.W(16), .MASK(PREF_MASK)) u_pf_base (
    .clk_i, .rst_ni, .we_i(wr_pf), .be_i(cfg_be_i[1:0]),
    .wdata_i(cfg_wdata_i[15:0]), .q_o(pf_base_q));
  p2p_masked_reg #(.W(16), .MASK(PREF_MASK)) u_pf_lim (
    .clk_i, .rst_ni, .we_i(wr_pf), .be_i(cfg_be_i[3:2]),
    .wdata_i(cfg_wdata_i[31:16]), .q_o(pf_lim_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q        <= '0;
      pf_up_base_q <= '0;
      pf_up_lim_q  <= '0;
      io_up_q      <= '0;
      rom_q        <= '0;
      brctl_q      <= '0;
      irq_line_q   <= '0;
    end else begin
      if (wr_bus) bus_q <= lane_merge({8'h00, bus_q}, cfg_wdata_i, cfg_be_i)[23:0];
      if (wr_pfub && pf_wide) pf_up_base_q <= lane_merge(pf_up_base_q, cfg_wdata_i, cfg_be_i);
      if (wr_pful && pf_wide) pf_up_lim_q  <= lane_merge(pf_up_lim_q, cfg_wdata_i, cfg_be_i);
      if (wr_ioup && io_wide) io_up_q      <= lane_merge(io_up_q, cfg_wdata_i, cfg_be_i);
      if (wr_rom) rom_q <= lane_merge(rom_q, cfg_wdata_i, cfg_be_i) & ROM_MASK;
      if (wr_irq) begin
        if (cfg_be_i[0]) irq_line_q     <= cfg_wdata_i[7:0];
        if (cfg_be_i[2]) brctl_q[7:0]   <= cfg_wdata_i[23:16];
        if (cfg_be_i[3]) brctl_q[15:8]  <= cfg_wdata_i[31:24];
      end
    end
  end

  always_comb begin
    unique case (cfg_dw_i)
      DW_BUS:    cfg_rdata_o = {sec_lat_o, bus_q};
      DW_IO:     cfg_rdata_o = {16'h0000, io_lim_q, io_base_q};
      DW_MEM:    cfg_rdata_o = {mem_lim_q, mem_base_q};
      DW_PF:     cfg_rdata_o = {pf_lim_q, pf_base_q};
      DW_PF_UPB: cfg_rdata_o = pf_up_base_q;
      DW_PF_UPL: cfg_rdata_o = pf_up_lim_q;
      DW_IO_UP:  cfg_rdata_o = io_up_q;
      DW_ROM:    cfg_rdata_o = rom_q;
      DW_IRQ:    cfg_rdata_o = {brctl_q, IRQ_PIN, irq_line_q};
      default:   cfg_rdata_o = '0;
    endcase
  end

  assign pri_bus_o    = bus_q[7:0];
  assign sec_bus_o    = bus_q[15:8];
  assign sub_bus_o    = bus_q[23:16];
  assign rom_addr_o   = rom_q;
  assign bridge_ctl_o = brctl_q;
  assign irq_line_o   = irq_line_q;

  p2p_window_dec u_win (
    .io_base_i(io_base_q), .io_lim_i(io_lim_q), .io_up_i(io_up_q),
    .mem_base_i(mem_base_q), .mem_lim_i(mem_lim_q),
    .pf_base_i(pf_base_q), .pf_lim_i(pf_lim_q),
    .pf_up_base_i(pf_up_base_q), .pf_up_lim_i(pf_up_lim_q),
    .io_base_o(io_win_base_o), .io_lim_o(io_win_limit_o),
    .mem_base_o(mem_win_base_o), .mem_lim_o(mem_win_limit_o),
    .pf_base_o(pf_win_base_o), .pf_lim_o(pf_win_limit_o));

  p_fwd_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_fwd_o) |=> ($stable(bus_q) && $stable(io_up_q) && $stable(rom_q) &&
                                 $stable(pf_up_base_q) && $stable(brctl_q)));
  p_io_up_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wide |=> $stable(io_up_q));
  p_pf_up_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pf_wide |=> ($stable(pf_up_base_q) && $stable(pf_up_lim_q)));
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_dw_i > DW_IRQ) |=> ($stable(bus_q) && $stable(rom_q) &&
                                         $stable(irq_line_q) && $stable(io_up_q)));
endmodule

// File: tb/p2p_bridge_cfg_bench.sv
module p2p_bridge_cfg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  LM  = 8'hF8;
  localparam logic [7:0]  IOA = 8'hF1, IOB = 8'hF0;
  localparam logic [15:0] MM  = 16'hFFF0;
  localparam logic [15:0] PMA = 16'hFFF1, PMB = 16'hFFF0;
  localparam logic [31:0] RM  = 32'hFFFF_F801;
  localparam logic [7:0]  PIN = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] dw = '0;
  logic [3:0] be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_a, rd_b;
  logic fwd_a, fwd_b;
  logic [7:0] pri_a, sec_a, sub_a, lat_a, irq_a, pri_b, sec_b, sub_b, lat_b, irq_b;
  logic [31:0] iob_a, iol_a, mb_a, ml_a, rom_a, iob_b, iol_b, mb_b, ml_b, rom_b;
  logic [63:0] pb_a, pl_a, pb_b, pl_b;
  logic [15:0] bc_a, bc_b;

  int n_run = 0, n_fail = 0;
  logic [31:0] img_a [16];
  logic [31:0] img_b [16];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  p2p_bridge_cfg u_p2p_bridge_cfg (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_dw_i(dw), .cfg_be_i(be),
    .cfg_wdata_i(wd), .cfg_rdata_o(rd_a), .cfg_fwd_o(fwd_a),
    .pri_bus_o(pri_a), .sec_bus_o(sec_a), .sub_bus_o(sub_a), .sec_lat_o(lat_a),
    .io_win_base_o(iob_a), .io_win_limit_o(iol_a), .mem_win_base_o(mb_a),
    .mem_win_limit_o(ml_a), .pf_win_base_o(pb_a), .pf_win_limit_o(pl_a),
    .rom_addr_o(rom_a), .bridge_ctl_o(bc_a), .irq_line_o(irq_a));

  p2p_bridge_cfg #(.IO_MASK(IOB), .PREF_MASK(PMB)) u_p2p_bridge_cfg_narrow (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_dw_i(dw), .cfg_be_i(be),
    .cfg_wdata_i(wd), .cfg_rdata_o(rd_b), .cfg_fwd_o(fwd_b),
    .pri_bus_o(pri_b), .sec_bus_o(sec_b), .sub_bus_o(sub_b), .sec_lat_o(lat_b),
    .io_win_base_o(iob_b), .io_win_limit_o(iol_b), .mem_win_base_o(mb_b),
    .mem_win_limit_o(ml_b), .pf_win_base_o(pb_b), .pf_win_limit_o(pl_b),
    .rom_addr_o(rom_b), .bridge_ctl_o(bc_b), .irq_line_o(irq_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] d, logic [3:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = b[i] ? d[i*8 +: 8] : o[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] bl16(logic [15:0] v, logic [15:0] m);
    return (v & m) | {12'h000, m[3:0]};
  endfunction

  function automatic logic [31:0] mdl(int idx, logic [31:0] o, logic [31:0] d, logic [3:0] b,
                                      logic [7:0] iom, logic [15:0] pm);
    logic [31:0] r, t;
    r = o;
    t = mrg(o, d, b);
    case (idx)
      6:  begin r = t; if (b[3]) r[31:24] = (o[31:24] & ~LM) | (d[31:24] & LM); end
      7:  begin
            if (b[0]) r[7:0]  = (d[7:0]  & iom) | {4'h0, iom[3:0]};
            if (b[1]) r[15:8] = (d[15:8] & iom) | {4'h0, iom[3:0]};
          end
      8:  r = {bl16(t[31:16], MM), bl16(t[15:0], MM)};
      9:  r = {bl16(t[31:16], pm), bl16(t[15:0], pm)};
      10, 11: if (pm[3:0] == 4'h1) r = t;
      12: if (iom[3:0] == 4'h1) r = t;
      14: r = t & RM;
      15: r = {t[31:16], o[15:8], t[7:0]};
      default: r = o;
    endcase
    return r;
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      6: return "R2/R3";  7: return "R4/R5";  8, 9: return "R4";
      10, 11: return "R7";  12: return "R6";  13: return "R9";
      14: return "R13";  15: return "R8";  default: return "R1";
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    we = 1'b1; dw = a; wd = d; be = b;
    @(negedge clk);
    we = 1'b0;
    if (a >= 6'd6 && a <= 6'd15) begin
      img_a[a[3:0]] = mdl(int'(a), img_a[a[3:0]], d, b, IOA, PMA);
      img_b[a[3:0]] = mdl(int'(a), img_b[a[3:0]], d, b, IOB, PMB);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int i = 0; i < 16; i++) begin
      dw = 6'(i);
      #1;
      if (i < 6) begin
        chk({"R1 fwd ", ctx}, {63'd0, fwd_a}, 64'd1);
        chk({"R1 rdata ", ctx}, {32'd0, rd_a}, 64'd0);
      end else begin
        chk({"R1 nofwd ", ctx}, {62'd0, fwd_a, fwd_b}, 64'd0);
        chk({tag_of(i), " A ", ctx}, {32'd0, rd_a}, {32'd0, img_a[i]});
        chk({tag_of(i), " B ", ctx}, {32'd0, rd_b}, {32'd0, img_b[i]});
      end
    end
    chk({"R11 io A ", ctx}, {iob_a, iol_a},
        {img_a[12][15:0], img_a[7][7:4], 12'h000, img_a[12][31:16], img_a[7][15:12], 12'hFFF});
    chk({"R11 mem A ", ctx}, {mb_a, ml_a},
        {img_a[8][15:4], 20'h0, img_a[8][31:20], 20'hFFFFF});
    chk({"R11 pfb A ", ctx}, pb_a, {img_a[10], img_a[9][15:4], 20'h0});
    chk({"R11 pfl A ", ctx}, pl_a, {img_a[11], img_a[9][31:20], 20'hFFFFF});
    chk({"R11 io B ", ctx}, {iob_b, iol_b},
        {img_b[12][15:0], img_b[7][7:4], 12'h000, img_b[12][31:16], img_b[7][15:12], 12'hFFF});
    chk({"R11 pfl B ", ctx}, pl_b, {img_b[11], img_b[9][31:20], 20'hFFFFF});
    chk({"R2 bus ", ctx}, {32'd0, lat_a, sub_a, sec_a, pri_a}, {32'd0, img_a[6]});
    chk({"R8/R13 out ", ctx}, {rom_a, bc_a, irq_a, 8'h00},
        {img_a[14], img_a[15][31:16], img_a[15][7:0], 8'h00});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin img_a[i] = '0; img_b[i] = '0; end
    img_a[7]  = {16'h0, 4'h0, IOA[3:0], 4'h0, IOA[3:0]};
    img_b[7]  = {16'h0, 4'h0, IOB[3:0], 4'h0, IOB[3:0]};
    img_a[8]  = {12'h0, MM[3:0], 12'h0, MM[3:0]};
    img_b[8]  = img_a[8];
    img_a[9]  = {12'h0, PMA[3:0], 12'h0, PMA[3:0]};
    img_b[9]  = {12'h0, PMB[3:0], 12'h0, PMB[3:0]};
    img_a[15] = {16'h0, PIN, 8'h00};
    img_b[15] = img_a[15];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 reset");

    // R12: no strobe, no change
    @(negedge clk);
    we = 1'b0; dw = 6'd6; wd = 32'hFFFF_FFFF; be = 4'hF;
    @(negedge clk);
    check_all("R12 no strobe");

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int p = 0; p < 3; p++) begin
          logic [31:0] d;
          seed = seed * 32'd1664525 + 32'd1013904223;
          d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0000 : seed;
          wr(6'(a), d, 4'(b));
          check_all("R12 sweep");
        end
      end
    end

    // R9: high unmapped indices read zero and ignore writes
    for (int a = 16; a < 64; a++) begin
      wr(6'(a), 32'hA5A5_5A5A, 4'hF);
      dw = 6'(a);
      #1;
      chk("R9 high read", {32'd0, rd_a}, 64'd0);
    end
    check_all("R9 after high writes");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule